// File: doc/BRIEF.md
# Erase Suspend Guard

This block sits on the host side of a flash command port and decides when an erase may be paused so that an interrupt-driven reader can get at the array. A read that arrives while an erase is running is held as pending. The suspend command goes out only after the erase has run without a break for a programmable number of cycles, counted from the last erase launch or resume. This lets at least one full internal erase pulse finish between pauses. The host clock has no fixed phase relation to the flash pulse generator, so the interval has to cover a whole pulse, and a built-in floor enforces this. The erase slows down by roughly 1/(1 - P/(2T)), where P is the pulse length and T is the spacing between suspends. The block reports the cycles spent suspended so software can see what that cost.

The reader uses a level handshake. It raises `rd_req_i` and holds it high. `rd_gnt_o` is high only while `rd_req_i` is high and the flash is free to read: either no erase is running, or the flash has reported that it is suspended. When the reader drops the request, the grant falls in the same cycle and a resume command follows one cycle later. No back-pressure applies to the command strobes. Each strobe is a single-cycle pulse that the flash port must accept.

The block counts suspends within one erase. When the count reaches the limit, it raises a flag. When that erase then completes, the block launches the erase again. A warning flag latches if a read arrives too soon after the erase last started running, which shows that suspends are becoming frequent rather than sporadic.

Top module: `erase_susp_guard`

## Requirements
- R1: During and straight after reset, every command strobe, `rd_gnt_o`, `busy_o`, `limit_hit_o` and `freq_warn_o` are low, and `susp_count_o` and `lost_cycles_o` are zero.
- R2: When `erase_go_i` is sampled high while idle with `rd_req_i` low, `cmd_erase_o` pulses for exactly one cycle in the next cycle and `busy_o` rises with it. `erase_go_i` has no effect while busy or while `rd_req_i` is high.
- R3: While idle, `rd_gnt_o` follows `rd_req_i` in the same cycle, and no suspend or resume strobe is issued.
- R4: Let M be the effective minimum run and let the last erase or resume strobe fall in cycle c. A read that is pending from cycle q produces its suspend strobe in cycle max(q, c+M)+1, and never earlier than c+M+1.
- R5: The effective minimum run M is the larger of `min_run_i` and the parameter MIN_FLOOR.
- R6: After a suspend strobe, `rd_gnt_o` rises in the cycle after the first cycle in which `fl_suspended_i` is high. `rd_gnt_o` is never high while `rd_req_i` is low.
- R7: If `rd_req_i` is low in cycle k while granted during an erase, `rd_gnt_o` is low in cycle k and `cmd_resume_o` pulses in cycle k+1.
- R8: If `fl_done_i` arrives while a read is pending (before any suspend, or after the suspend strobe but before `fl_suspended_i`), the erase ends with no resume strobe. `busy_o` falls and `rd_gnt_o` rises in the next cycle, and no further suspend strobe is issued.
- R9: `susp_count_o` rises by one on each suspend strobe, saturates at SUSP_LIMIT, and reads zero in the cycle of every erase strobe. `limit_hit_o` is high exactly when the count equals SUSP_LIMIT.
- R10: When `fl_done_i` arrives with `limit_hit_o` high and no grant outstanding, `cmd_erase_o` pulses in the next cycle, `busy_o` stays high, and the count, the lost-cycle total and the warning are cleared.
- R11: `lost_cycles_o` adds one for every cycle from a suspend strobe up to the cycle before the matching resume strobe (or up to and including the `fl_done_i` cycle on cancellation). It reads zero in the cycle of every erase strobe.
- R12: `freq_warn_o` sets when `rd_req_i` rises while an erase runs and fewer than `warn_gap_i` cycles have passed since the last erase or resume strobe (that strobe's cycle counts as zero). It stays set until the next erase strobe.
- R13: When `fl_done_i` arrives while running with no read pending and the limit not reached, `busy_o` is low in the next cycle and no strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| erase_go_i | input | 1 | Request to launch an erase |
| rd_req_i | input | 1 | Read request, held until granted and served |
| rd_gnt_o | output | 1 | Read may proceed |
| fl_suspended_i | input | 1 | Flash reports erase paused |
| fl_done_i | input | 1 | Flash reports erase finished (one-cycle pulse) |
| cmd_erase_o | output | 1 | Erase command strobe |
| cmd_suspend_o | output | 1 | Suspend command strobe |
| cmd_resume_o | output | 1 | Resume command strobe |
| min_run_i | input | RUN_W | Minimum uninterrupted run, in cycles |
| warn_gap_i | input | RUN_W | Request-spacing warning threshold, in cycles |
| busy_o | output | 1 | An erase is in progress |
| susp_count_o | output | CNT_W | Suspends issued during the current erase |
| limit_hit_o | output | 1 | Suspend count reached SUSP_LIMIT |
| lost_cycles_o | output | LOST_W | Cycles spent suspended during the current erase |
| freq_warn_o | output | 1 | Reads are arriving too soon after the erase restarts |

## Verification
The suspend timing is driven with requests that arrive before the interval expires and requests that arrive after it. This tells a correct max(q, c+M)+1 apart from a design that counts from the request or ignores the run time. Intervals below the floor separate clamping from passing the programmed value through. Completion is injected in three positions: before the suspend, during the wait for the flash, and with no request pending. These show cancellation and plain completion. Long runs of suspends push the counter past its limit, which exposes both saturation and the reissue. Random episodes vary the interval, the request delay, the hold time and the flash latency, and compare strobe cycles, lost-cycle totals and the warning against bench arithmetic.

// File: rtl/esg_pkg.sv
package esg_pkg;
  typedef enum logic [1:0] {
    ESG_IDLE  = 2'd0,
    ESG_RUN   = 2'd1,
    ESG_HOLD  = 2'd2,
    ESG_GRANT = 2'd3
  } esg_state_e;
endpackage

// File: rtl/esg_run_timer.sv
// Counts cycles of uninterrupted erase since the last launch or resume and
// reports when the effective minimum run has been reached.
module esg_run_timer #(
  parameter int RUN_W     = 22,
  parameter int MIN_FLOOR = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload_i,
  input  logic [RUN_W-1:0] min_run_i,
  output logic [RUN_W-1:0] elapsed_o,
  output logic             run_ok_o
);
  localparam logic [RUN_W-1:0] FLOOR_V = RUN_W'(MIN_FLOOR);

  logic [RUN_W-1:0] elapsed_q;
  logic [RUN_W-1:0] eff_min;

  // Programmed value is clamped up to a whole pulse length.
  assign eff_min = (min_run_i < FLOOR_V) ? FLOOR_V : min_run_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elapsed_q <= '0;
    end else if (reload_i) begin
      elapsed_q <= '0;
    end else if (elapsed_q != '1) begin
      elapsed_q <= elapsed_q + 1'b1;
    end
  end

  assign elapsed_o = elapsed_q;
  assign run_ok_o  = (elapsed_q >= eff_min);
endmodule

// File: rtl/esg_ledger.sv
// Per-erase bookkeeping: suspend count with limit flag and suspended-cycle total.
module esg_ledger #(
  parameter int SUSP_LIMIT = 5680,
  parameter int CNT_W      = 13,
  parameter int LOST_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_erase_i,
  input  logic              launch_suspend_i,
  input  logic              halted_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              limit_hit_o,
  output logic [LOST_W-1:0] lost_o
);
  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(SUSP_LIMIT);

  logic [CNT_W-1:0]  count_q;
  logic [LOST_W-1:0] lost_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (launch_erase_i) begin
      count_q <= '0;
    end else if (launch_suspend_i && (count_q < LIMIT_V)) begin
      count_q <= count_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lost_q <= '0;
    end else if (launch_erase_i) begin
      lost_q <= '0;
    end else if (halted_i && (lost_q != '1)) begin
      lost_q <= lost_q + 1'b1;
    end
  end

  assign count_o     = count_q;
  assign limit_hit_o = (count_q == LIMIT_V);
  assign lost_o      = lost_q;
endmodule

// File: rtl/esg_rate_mon.sv
// Latches a warning when a read shows up too soon after the erase restarted.
module esg_rate_mon #(
  parameter int RUN_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_req_i,
  input  logic             in_run_i,
  input  logic             clear_i,
  input  logic [RUN_W-1:0] elapsed_i,
  input  logic [RUN_W-1:0] warn_gap_i,
  output logic             warn_o
);
  logic req_d;
  logic warn_q;
  logic req_rise;

  assign req_rise = rd_req_i && !req_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_d <= 1'b0;
    end else begin
      req_d <= rd_req_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      warn_q <= 1'b0;
    end else if (clear_i) begin
      warn_q <= 1'b0;
    end else if (req_rise && in_run_i && (elapsed_i < warn_gap_i)) begin
      warn_q <= 1'b1;
    end
  end

  assign warn_o = warn_q;
endmodule

// File: rtl/esg_ctrl.sv
// Sequencer: launch, pending read, suspend wait, grant, resume, reissue.
module esg_ctrl
  import esg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       erase_go_i,
  input  logic       rd_req_i,
  input  logic       fl_suspended_i,
  input  logic       fl_done_i,
  input  logic       run_ok_i,
  input  logic       limit_hit_i,
  output esg_state_e state_o,
  output logic       launch_erase_o,
  output logic       launch_suspend_o,
  output logic       launch_resume_o,
  output logic       cmd_erase_o,
  output logic       cmd_suspend_o,
  output logic       cmd_resume_o,
  output logic       rd_gnt_o
);
  esg_state_e state_q, state_d;
  logic le, ls, lr;
  logic erase_q, susp_q, res_q;

  always_comb begin
    state_d = state_q;
    le      = 1'b0;
    ls      = 1'b0;
    lr      = 1'b0;
    unique case (state_q)
      ESG_IDLE: begin
        if (erase_go_i && !rd_req_i) begin
          state_d = ESG_RUN;
          le      = 1'b1;
        end
      end
      ESG_RUN: begin
        if (fl_done_i) begin
          if (limit_hit_i) begin
            le = 1'b1;
          end else begin
            state_d = ESG_IDLE;
          end
        end else if (rd_req_i && run_ok_i) begin
          state_d = ESG_HOLD;
          ls      = 1'b1;
        end
      end
      ESG_HOLD: begin
        // Completion beats the pause: cancel and serve the read directly.
        if (fl_done_i) begin
          if (limit_hit_i) begin
            state_d = ESG_RUN;
            le      = 1'b1;
          end else begin
            state_d = ESG_IDLE;
          end
        end else if (fl_suspended_i) begin
          state_d = ESG_GRANT;
        end
      end
      ESG_GRANT: begin
        if (!rd_req_i) begin
          state_d = ESG_RUN;
          lr      = 1'b1;
        end
      end
      default: state_d = ESG_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ESG_IDLE;
      erase_q <= 1'b0;
      susp_q  <= 1'b0;
      res_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      erase_q <= le;
      susp_q  <= ls;
      res_q   <= lr;
    end
  end

  assign state_o          = state_q;
  assign launch_erase_o   = le;
  assign launch_suspend_o = ls;
  assign launch_resume_o  = lr;
  assign cmd_erase_o      = erase_q;
  assign cmd_suspend_o    = susp_q;
  assign cmd_resume_o     = res_q;
  assign rd_gnt_o = rd_req_i && ((state_q == ESG_IDLE) || (state_q == ESG_GRANT));
endmodule

// File: rtl/erase_susp_guard.sv
module erase_susp_guard
  import esg_pkg::*;
#(
  parameter int CLK_MHZ    = 250,
  parameter int MAX_RUN_US = 10000,
  parameter int MIN_FLOOR  = 500,
  parameter int SUSP_LIMIT = 5680,
  parameter int LOST_W     = 32,
  localparam int RUN_W     = $clog2(CLK_MHZ * MAX_RUN_US + 1),
  localparam int CNT_W     = $clog2(SUSP_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_go_i,
  input  logic              rd_req_i,
  output logic              rd_gnt_o,
  input  logic              fl_suspended_i,
  input  logic              fl_done_i,
  output logic              cmd_erase_o,
  output logic              cmd_suspend_o,
  output logic              cmd_resume_o,
  input  logic [RUN_W-1:0]  min_run_i,
  input  logic [RUN_W-1:0]  warn_gap_i,
  output logic              busy_o,
  output logic [CNT_W-1:0]  susp_count_o,
  output logic              limit_hit_o,
  output logic [LOST_W-1:0] lost_cycles_o,
  output logic              freq_warn_o
);
  esg_state_e       state;
  logic             launch_erase, launch_suspend, launch_resume;
  logic             run_ok;
  logic [RUN_W-1:0] elapsed;

  esg_ctrl u_ctrl (
    .clk              (clk),
    .rst_n            (rst_n),
    .erase_go_i       (erase_go_i),
    .rd_req_i         (rd_req_i),
    .fl_suspended_i   (fl_suspended_i),
    .fl_done_i        (fl_done_i),
    .run_ok_i         (run_ok),
    .limit_hit_i      (limit_hit_o),
    .state_o          (state),
    .launch_erase_o   (launch_erase),
    .launch_suspend_o (launch_suspend),
    .launch_resume_o  (launch_resume),
    .cmd_erase_o      (cmd_erase_o),
    .cmd_suspend_o    (cmd_suspend_o),
    .cmd_resume_o     (cmd_resume_o),
    .rd_gnt_o         (rd_gnt_o)
  );

  esg_run_timer #(.RUN_W(RUN_W), .MIN_FLOOR(MIN_FLOOR)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .reload_i  (launch_erase || launch_resume),
    .min_run_i (min_run_i),
    .elapsed_o (elapsed),
    .run_ok_o  (run_ok)
  );

  esg_ledger #(.SUSP_LIMIT(SUSP_LIMIT), .CNT_W(CNT_W), .LOST_W(LOST_W)) u_ledger (
    .clk              (clk),
    .rst_n            (rst_n),
    .launch_erase_i   (launch_erase),
    .launch_suspend_i (launch_suspend),
    .halted_i         ((state == ESG_HOLD) || (state == ESG_GRANT)),
    .count_o          (susp_count_o),
    .limit_hit_o      (limit_hit_o),
    .lost_o           (lost_cycles_o)
  );

  esg_rate_mon #(.RUN_W(RUN_W)) u_rate (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req_i   (rd_req_i),
    .in_run_i   (state == ESG_RUN),
    .clear_i    (launch_erase),
    .elapsed_i  (elapsed),
    .warn_gap_i (warn_gap_i),
    .warn_o     (freq_warn_o)
  );

  assign busy_o = (state != ESG_IDLE);
endmodule

// File: rtl/esg_guard_chk.sv
module esg_guard_chk
  import esg_pkg::*;
#(
  parameter int MIN_FLOOR  = 500,
  parameter int SUSP_LIMIT = 5680,
  parameter int RUN_W      = 22,
  parameter int CNT_W      = 13,
  parameter int LOST_W     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req_i,
  input logic              rd_gnt_o,
  input logic              fl_suspended_i,
  input logic              fl_done_i,
  input logic              cmd_erase_o,
  input logic              cmd_suspend_o,
  input logic              cmd_resume_o,
  input logic [RUN_W-1:0]  min_run_i,
  input logic              busy_o,
  input logic [CNT_W-1:0]  susp_count_o,
  input logic              limit_hit_o,
  input logic [LOST_W-1:0] lost_cycles_o,
  input logic              freq_warn_o,
  input esg_state_e        state
);
  logic [RUN_W:0] since_q;
  logic [RUN_W:0] need;

  // Independent distance counter: 1 in the cycle after an erase/resume strobe.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_q <= '0;
    end else if (cmd_erase_o || cmd_resume_o) begin
      since_q <= (RUN_W+1)'(1);
    end else if (since_q != '1) begin
      since_q <= since_q + 1'b1;
    end
  end

  assign need = (min_run_i < RUN_W'(MIN_FLOOR)) ? (RUN_W+1)'(MIN_FLOOR) + 1'b1
                                                : {1'b0, min_run_i} + 1'b1;

  p_strobe_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_erase_o, cmd_suspend_o, cmd_resume_o}));

  p_strobe_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_suspend_o |=> !cmd_suspend_o);

  p_min_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_suspend_o |-> since_q >= $past(need));

  p_gnt_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_gnt_o |-> rd_req_i);

  p_gnt_after_flash_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_gnt_o) && busy_o) |-> $past(fl_suspended_i));

  p_resume_after_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_resume_o |-> (!$past(rd_req_i) && $past(busy_o)));

  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    susp_count_o <= CNT_W'(SUSP_LIMIT));

  p_reissue_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (((state == ESG_RUN) || (state == ESG_HOLD)) && limit_hit_o && fl_done_i)
      |=> (cmd_erase_o && busy_o && (susp_count_o == '0)));

  p_lost_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ESG_RUN) || (state == ESG_IDLE)) |=> (cmd_erase_o || $stable(lost_cycles_o)));

  p_warn_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    freq_warn_o |=> (freq_warn_o || cmd_erase_o));
endmodule

bind erase_susp_guard esg_guard_chk #(
  .MIN_FLOOR (MIN_FLOOR),
  .SUSP_LIMIT(SUSP_LIMIT),
  .RUN_W     (RUN_W),
  .CNT_W     (CNT_W),
  .LOST_W    (LOST_W)
) i_esg_guard_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .rd_req_i       (rd_req_i),
  .rd_gnt_o       (rd_gnt_o),
  .fl_suspended_i (fl_suspended_i),
  .fl_done_i      (fl_done_i),
  .cmd_erase_o    (cmd_erase_o),
  .cmd_suspend_o  (cmd_suspend_o),
  .cmd_resume_o   (cmd_resume_o),
  .min_run_i      (min_run_i),
  .busy_o         (busy_o),
  .susp_count_o   (susp_count_o),
  .limit_hit_o    (limit_hit_o),
  .lost_cycles_o  (lost_cycles_o),
  .freq_warn_o    (freq_warn_o),
  .state          (state)
);

// File: tb/test_erase_susp_guard.sv
`timescale 1ns/100ps
module test_erase_susp_guard;
  localparam int FLOOR = 3;
  localparam int LIM   = 4;
  localparam int RUN_W = 22;
  localparam int CNT_W = 3;
  localparam int LOST_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic erase_go = 1'b0, rd_req = 1'b0, fl_sus = 1'b0, fl_done = 1'b0;
  logic [RUN_W-1:0] min_run = '0, warn_gap = '0;
  logic rd_gnt, c_erase, c_susp, c_res, busy, limit_hit, warn;
  logic [CNT_W-1:0] scount;
  logic [LOST_W-1:0] lost;

  int n_tests = 0, n_fail = 0;
  int cyc = 0;
  int n_erase = 0, n_susp = 0, n_res = 0;
  int s_cyc = 0, cd = 0, lat = 2;
  int ref_c = 0, exp_cnt = 0, exp_lost = 0;
  bit exp_warn = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  erase_susp_guard #(.MIN_FLOOR(FLOOR), .SUSP_LIMIT(LIM)) i_erase_susp_guard (
    .clk(clk), .rst_n(rst_n), .erase_go_i(erase_go), .rd_req_i(rd_req), .rd_gnt_o(rd_gnt),
    .fl_suspended_i(fl_sus), .fl_done_i(fl_done), .cmd_erase_o(c_erase),
    .cmd_suspend_o(c_susp), .cmd_resume_o(c_res), .min_run_i(min_run), .warn_gap_i(warn_gap),
    .busy_o(busy), .susp_count_o(scount), .limit_hit_o(limit_hit),
    .lost_cycles_o(lost), .freq_warn_o(warn));

  // Strobe monitor and simple flash model, acting at the falling edge.
  always @(negedge clk) begin
    if (c_erase) begin n_erase++; fl_sus = 1'b0; cd = 0; end
    if (c_susp) begin n_susp++; s_cyc = cyc; cd = lat; end
    else if (cd != 0) begin cd--; if (cd == 0) fl_sus = 1'b1; end
    if (c_res) begin n_res++; fl_sus = 1'b0; end
  end

  task automatic chk(string tag, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic smp(); @(negedge clk); #1; endtask
  task automatic nxt(); @(posedge clk); #1; endtask

  function automatic int eff(int m); return (m < FLOOR) ? FLOOR : m; endfunction
  function automatic int mx(int a, int b); return (a > b) ? a : b; endfunction

  task automatic start_erase();
    nxt(); erase_go = 1'b1;
    nxt(); erase_go = 1'b0;
    smp();
    chk("R2 erase strobe", c_erase, 1);
    chk("R2 busy", busy, 1);
    chk("R9 count cleared", scount, 0);
    chk("R11 lost cleared", lost, 0);
    chk("R12 warn cleared", warn, 0);
    ref_c = cyc; exp_cnt = 0; exp_lost = 0; exp_warn = 0;
  endtask

  task automatic episode(int m, int d, int h);
    int q, es, g, ns0, r;
    min_run = RUN_W'(m);
    repeat (d) nxt();
    rd_req = 1'b1; q = cyc;
    es = mx(q, ref_c + eff(m)) + 1;
    if (q - ref_c < int'(warn_gap)) exp_warn = 1;
    ns0 = n_susp;
    for (int i = 0; i < 300 && n_susp == ns0; i++) smp();
    chk("R4 suspend cycle", s_cyc, es);
    for (int i = 0; i < 300 && !rd_gnt; i++) smp();
    g = cyc;
    chk("R6 grant cycle", g, s_cyc + lat + 1);
    repeat (h) nxt();
    nxt(); rd_req = 1'b0;
    smp(); chk("R7 grant drops", rd_gnt, 0);
    smp(); chk("R7 resume strobe", c_res, 1);
    r = cyc;
    exp_lost += r - s_cyc;
    if (exp_cnt < LIM) exp_cnt++;
    chk("R11 lost total", lost, exp_lost);
    chk("R9 count", scount, exp_cnt);
    chk("R9 limit flag", limit_hit, exp_cnt == LIM);
    chk("R12 warn", warn, exp_warn);
    ref_c = r;
  endtask

  task automatic done_pulse(bit reissue);
    nxt(); fl_done = 1'b1;
    nxt(); fl_done = 1'b0;
    smp();
    if (reissue) begin
      chk("R10 reissue strobe", c_erase, 1);
      chk("R10 busy kept", busy, 1);
      chk("R10 count cleared", scount, 0);
      chk("R10 lost cleared", lost, 0);
      chk("R10 warn cleared", warn, 0);
      ref_c = cyc; exp_cnt = 0; exp_lost = 0; exp_warn = 0;
    end else begin
      chk("R13 idle after done", busy, 0);
      chk("R13 no strobe", c_erase | c_susp | c_res, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int ne, ns, nr, q;
    void'($urandom(32'd915));
    repeat (3) smp();
    chk("R1 strobes in reset", c_erase | c_susp | c_res | rd_gnt, 0);
    repeat (2) nxt();
    rst_n = 1'b1;
    smp();
    chk("R1 busy", busy, 0);
    chk("R1 count", scount, 0);
    chk("R1 lost", lost, 0);
    chk("R1 flags", limit_hit | warn, 0);

    // R3: read with no erase running
    ns = n_susp; nr = n_res;
    nxt(); rd_req = 1'b1; #0.5;
    chk("R3 immediate grant", rd_gnt, 1);
    // R2: launch ignored while a read is up
    erase_go = 1'b1; ne = n_erase;
    nxt(); erase_go = 1'b0;
    repeat (2) nxt();
    rd_req = 1'b0;
    smp();
    chk("R2 ignored with read", n_erase, ne);
    chk("R2 idle kept", busy, 0);
    chk("R3 no suspend", n_susp, ns);
    chk("R3 no resume", n_res, nr);

    // Directed: interval 5, request at launch
    min_run = 22'd5; warn_gap = 22'd3; lat = 2;
    start_erase();
    episode(5, 0, 2);
    // R2: launch ignored while busy
    ne = n_erase;
    nxt(); erase_go = 1'b1; nxt(); erase_go = 1'b0; repeat (2) smp();
    chk("R2 ignored while busy", n_erase, ne);
    // R5: below the floor
    episode(1, 0, 1);
    episode(0, 2, 0);
    episode(7, 9, 3);
    chk("R9 limit reached", limit_hit, 1);
    episode(2, 1, 0);  // saturation
    done_pulse(1'b1);
    done_pulse(1'b0);

    // R8: completion while pending, before suspend
    min_run = 22'd20;
    start_erase();
    ns = n_susp; nr = n_res;
    nxt(); rd_req = 1'b1;
    repeat (2) nxt();
    fl_done = 1'b1; nxt(); fl_done = 1'b0;
    smp();
    chk("R8 idle", busy, 0);
    chk("R8 grant", rd_gnt, 1);
    repeat (25) nxt();
    chk("R8 no suspend", n_susp, ns);
    chk("R11 lost unchanged", lost, 0);
    rd_req = 1'b0; repeat (2) smp();
    chk("R8 no resume", n_res, nr);

    // R8: completion while waiting for the flash to pause
    lat = 6; min_run = 22'd4;
    start_erase();
    rd_req = 1'b1; ns = n_susp;
    for (int i = 0; i < 50 && n_susp == ns; i++) smp();
    q = s_cyc;
    nxt(); fl_done = 1'b1; nxt(); fl_done = 1'b0;
    smp();
    chk("R8 cancel idle", busy, 0);
    chk("R8 cancel grant", rd_gnt, 1);
    chk("R11 lost on cancel", lost, 2);
    chk("R8 timing", cyc, q + 2);
    nr = n_res;
    repeat (3) nxt(); rd_req = 1'b0; repeat (3) smp();
    chk("R8 cancel no resume", n_res, nr);

    // Random episodes
    for (int e = 0; e < 40; e++) begin
      warn_gap = RUN_W'($urandom_range(0, 6));
      lat = $urandom_range(1, 3);
      start_erase();
      for (int k = 0, n = $urandom_range(0, 3); k < n; k++)
        episode($urandom_range(0, 9), $urandom_range(0, 6), $urandom_range(0, 5));
      repeat ($urandom_range(0, 4)) nxt();
      done_pulse(1'b0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule